// File: doc/BRIEF.md
# Memory-Operation Issue Queue

This block holds memory operations that dispatch has handed over and picks up to two of them each cycle for the two address pipes. Each entry records whether it is a load or a store, a tag, and whether its address is ready. Entries are kept in age order. Selection gives priority to the oldest operation that is ready. A cycle may send out two loads, or one load with one store, but never two stores. Stores leave only in program order with respect to each other. Loads may pass older stores.

A small counter follows the loads that have missed in the data cache. A miss report raises it and a miss return lowers it. When it reaches its limit, no load is picked until a return arrives, while stores keep flowing. A flush empties the queue. The counter is left to drain through the returns still on their way.

Top module: `lsq_issue_queue`

## Requirements
- R1: The queue holds up to DEPTH (24) entries. `disp_ready` is high exactly when at least two entries are free. While it is low, dispatch writes are dropped. Up to two entries are written per cycle, slot 0 before slot 1 in age.
- R2: Issue is oldest-ready-first. Slot 0 carries the oldest eligible entry and slot 1 the next older one. Slot 1 is never valid without slot 0.
- R3: A cycle issues at most two operations, and never two stores (`iss_is_store` bit 1 = store, 0 = load).
- R4: A ready store is not issued while an older store is still held, whether or not that older store is ready.
- R5: The miss count rises by one on `miss_report`, falls by one on `miss_return`, and stays the same when both arrive together. It never exceeds MISS_MAX (6).
- R6: While the miss count equals MISS_MAX, no load is issued. Ready stores still issue.
- R7: In a `flush` cycle nothing issues and that cycle's dispatch writes are dropped. From the next cycle the queue is empty. The miss count is unchanged by the flush.
- R8: An entry written with `disp_addr_rdy` low is not issued until `wake_valid` arrives with its tag. It becomes eligible from the cycle after the wake.
- R9: After reset the queue is empty, the miss count is zero, no issue slot is valid and `disp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all held entries |
| disp_valid | input | 2 | Dispatch write enables, slot 0 older |
| disp_is_store | input | 2 | Per slot: 1 = store, 0 = load |
| disp_addr_rdy | input | 2 | Per slot: address already available |
| disp_tag | input | 2*TAG_W | Per-slot tags, slot 0 in the low bits |
| disp_ready | output | 1 | At least two entries free |
| wake_valid | input | 1 | Address became ready for `wake_tag` |
| wake_tag | input | TAG_W | Tag whose address is now ready |
| miss_report | input | 1 | A load missed the data cache |
| miss_return | input | 1 | An outstanding miss completed |
| iss_valid | output | 2 | Issue slot valid, bit 0 = older |
| iss_is_store | output | 2 | Issue slot type, 1 = store |
| iss_tag | output | 2*TAG_W | Issue slot tags, slot 0 in the low bits |

## Verification
The checker takes for granted that `miss_report` comes only while the count is below MISS_MAX and that `miss_return` comes only while the count is above zero. It also assumes that a wake names a tag already in the queue. The stimulus follows its own miss count and raises reports and returns only within those bounds. Tags come from a rolling counter, and wakes go to the oldest entry that is not yet ready, so no wake names an entry being written in the same cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    parameter int TAG_W = 8;

    typedef struct packed {
        logic             st;
        logic             rdy;
        logic [TAG_W-1:0] tag;
    } lsq_entry_t;
endpackage

// File: rtl/lsq_pick.sv
// Age-ordered selector: index 0 is oldest. Stores are eligible only when
// no older store is held; loads only when the miss throttle is open.
module lsq_pick #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     is_st,
    input  logic [N-1:0]     rdy,
    input  logic             load_block,
    output logic [1:0]       pick_v,
    output logic [IDX_W-1:0] pick0,
    output logic [IDX_W-1:0] pick1
);
    always_comb begin
        logic store_seen;
        logic elig;
        store_seen = 1'b0;
        elig       = 1'b0;
        pick_v     = 2'b00;
        pick0      = '0;
        pick1      = '0;
        for (int i = 0; i < N; i++) begin
            elig = vld[i] && rdy[i] && (is_st[i] ? !store_seen : !load_block);
            if (vld[i] && is_st[i]) store_seen = 1'b1;
            if (elig) begin
                if (!pick_v[0]) begin
                    pick_v[0] = 1'b1;
                    pick0     = IDX_W'(i);
                end else if (!pick_v[1]) begin
                    pick_v[1] = 1'b1;
                    pick1     = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/lsq_miss_ctr.sv
module lsq_miss_ctr #(
    parameter int MAX = 6,
    parameter int W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         at_limit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != W'(MAX)) cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign at_limit = (cnt_q == W'(MAX));
endmodule

// File: rtl/lsq_issue_queue.sv
module lsq_issue_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH    = 24,
    parameter int MISS_MAX = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [1:0]         disp_valid,
    input  logic [1:0]         disp_is_store,
    input  logic [1:0]         disp_addr_rdy,
    input  logic [2*TAG_W-1:0] disp_tag,
    output logic               disp_ready,
    input  logic               wake_valid,
    input  logic [TAG_W-1:0]   wake_tag,
    input  logic               miss_report,
    input  logic               miss_return,
    output logic [1:0]         iss_valid,
    output logic [1:0]         iss_is_store,
    output logic [2*TAG_W-1:0] iss_tag
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int MCNT_W = $clog2(MISS_MAX + 1);

    typedef struct packed {
        lsq_entry_t [DEPTH-1:0] ents;
        logic [CNT_W-1:0]       used;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]  vld, is_st, rdy;
    logic [1:0]        pick_v;
    logic [IDX_W-1:0]  pick0, pick1;
    logic [MCNT_W-1:0] miss_cnt;
    logic              load_block;
    logic              accept;
    logic [CNT_W-1:0]  w;
    logic [CNT_W-1:0]  used_q;
    lsq_entry_t        ent;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flags
        assign vld[g]   = (CNT_W'(g) < st_q.used);
        assign is_st[g] = st_q.ents[g].st;
        assign rdy[g]   = st_q.ents[g].rdy;
    end

    lsq_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
        .vld        (vld),
        .is_st      (is_st),
        .rdy        (rdy),
        .load_block (load_block),
        .pick_v     (pick_v),
        .pick0      (pick0),
        .pick1      (pick1)
    );

    lsq_miss_ctr #(.MAX(MISS_MAX), .W(MCNT_W)) u_miss (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (miss_report),
        .dec      (miss_return),
        .count    (miss_cnt),
        .at_limit (load_block)
    );

    assign used_q     = st_q.used;
    assign disp_ready = (CNT_W'(DEPTH) - st_q.used) >= CNT_W'(2);
    assign accept     = disp_ready && !flush;

    always_comb begin
        st_d = st_q;
        w    = '0;
        ent  = '0;
        if (flush) begin
            st_d.used = '0;
        end else begin
            // keep survivors in age order, applying wakes
            for (int i = 0; i < DEPTH; i++) begin
                if (vld[i] && !(pick_v[0] && pick0 == IDX_W'(i))
                           && !(pick_v[1] && pick1 == IDX_W'(i))) begin
                    ent = st_q.ents[i];
                    if (wake_valid && ent.tag == wake_tag) ent.rdy = 1'b1;
                    st_d.ents[w[IDX_W-1:0]] = ent;
                    w = w + 1'b1;
                end
            end
            // append new writes behind survivors
            for (int k = 0; k < 2; k++) begin
                if (accept && disp_valid[k] && w < CNT_W'(DEPTH)) begin
                    st_d.ents[w[IDX_W-1:0]] = '{st:  disp_is_store[k],
                                                rdy: disp_addr_rdy[k],
                                                tag: disp_tag[k*TAG_W +: TAG_W]};
                    w = w + 1'b1;
                end
            end
            st_d.used = w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_valid    = pick_v & {2{!flush}};
    assign iss_is_store = {st_q.ents[pick1].st, st_q.ents[pick0].st} & iss_valid;
    assign iss_tag      = {st_q.ents[pick1].tag, st_q.ents[pick0].tag};
endmodule

// File: rtl/lsq_issue_queue_chk.sv
module lsq_issue_queue_chk #(
    parameter int DEPTH    = 24,
    parameter int MISS_MAX = 6,
    parameter int CNT_W    = 5,
    parameter int MCNT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              disp_ready,
    input logic [1:0]        iss_valid,
    input logic [1:0]        iss_is_store,
    input logic              miss_report,
    input logic              miss_return,
    input logic [CNT_W-1:0]  used,
    input logic [MCNT_W-1:0] miss_cnt
);
    assert_no_store_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == 2'b11 |-> iss_is_store != 2'b11);

    assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> iss_valid[0]);

    assert_load_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt == MCNT_W'(MISS_MAX) |->
            !(iss_valid[0] && !iss_is_store[0]) && !(iss_valid[1] && !iss_is_store[1]));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= MCNT_W'(MISS_MAX));

    assert_cnt_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_report && !miss_return && miss_cnt < MCNT_W'(MISS_MAX)
            |=> miss_cnt == $past(miss_cnt) + 1'b1);

    assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !miss_report && !miss_return |=> miss_cnt == $past(miss_cnt));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> used == '0);

    assert_no_growth_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ready |=> used <= $past(used));

    assert_capacity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CNT_W'(DEPTH));
endmodule

bind lsq_issue_queue lsq_issue_queue_chk #(
    .DEPTH(DEPTH), .MISS_MAX(MISS_MAX), .CNT_W(CNT_W), .MCNT_W(MCNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .disp_ready   (disp_ready),
    .iss_valid    (iss_valid),
    .iss_is_store (iss_is_store),
    .miss_report  (miss_report),
    .miss_return  (miss_return),
    .used         (used_q),
    .miss_cnt     (miss_cnt)
);

// File: tb/lsq_issue_queue_tb.sv
module lsq_issue_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 24;
    localparam int MISS_MAX   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  disp_valid = '0, disp_is_store = '0, disp_addr_rdy = '0;
    logic [15:0] disp_tag = '0;
    logic        disp_ready;
    logic        wake_valid = 1'b0;
    logic [7:0]  wake_tag = '0;
    logic        miss_report = 1'b0, miss_return = 1'b0;
    logic [1:0]  iss_valid, iss_is_store;
    logic [15:0] iss_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsq_issue_queue #(.DEPTH(DEPTH), .MISS_MAX(MISS_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store),
        .disp_addr_rdy(disp_addr_rdy), .disp_tag(disp_tag),
        .disp_ready(disp_ready), .wake_valid(wake_valid), .wake_tag(wake_tag),
        .miss_report(miss_report), .miss_return(miss_return),
        .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_tag(iss_tag)
    );

    typedef struct { int tag; bit st; bit rdy; } ment_t;
    ment_t mq[$];
    int    mcnt = 0;
    int    total = 0, fails = 0;
    bit    done = 1'b0;
    int    next_tag = 32;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, compare, advance the reference model
    task automatic step(input logic [1:0] dv, input logic [1:0] ds,
                        input logic [1:0] dr, input logic [15:0] dt,
                        input logic wv, input logic [7:0] wt,
                        input logic mrep, input logic mret, input logic fl);
        int  idx[2];
        int  n;
        bit  seen;
        bit  e;
        bit  exp_rdy;
        logic [1:0] ev;
        @(negedge clk);
        disp_valid = dv; disp_is_store = ds; disp_addr_rdy = dr; disp_tag = dt;
        wake_valid = wv; wake_tag = wt; miss_report = mrep; miss_return = mret;
        flush = fl;
        #1;
        n = 0; seen = 1'b0; idx[0] = 0; idx[1] = 0;
        foreach (mq[i]) begin
            e = mq[i].rdy && (mq[i].st ? !seen : (mcnt < MISS_MAX));
            if (mq[i].st) seen = 1'b1;
            if (e && n < 2) begin idx[n] = i; n++; end
        end
        if (fl) n = 0;
        ev = (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : 2'b11;
        exp_rdy = (DEPTH - mq.size()) >= 2;
        chk(disp_ready == exp_rdy, "R1", "disp_ready", int'(disp_ready), int'(exp_rdy));
        chk(iss_valid == ev, "R2", "iss_valid", int'(iss_valid), int'(ev));
        if (n >= 1) begin
            chk(iss_tag[7:0] == 8'(mq[idx[0]].tag), "R2", "slot0 tag",
                int'(iss_tag[7:0]), mq[idx[0]].tag);
            chk(iss_is_store[0] == mq[idx[0]].st, "R4", "slot0 type",
                int'(iss_is_store[0]), int'(mq[idx[0]].st));
        end
        if (n == 2) begin
            chk(iss_tag[15:8] == 8'(mq[idx[1]].tag), "R2", "slot1 tag",
                int'(iss_tag[15:8]), mq[idx[1]].tag);
            chk(iss_is_store != 2'b11, "R3", "store pair", int'(iss_is_store), 1);
        end
        // model update
        if (fl) mq.delete();
        else begin
            if (n == 2) mq.delete(idx[1]);
            if (n >= 1) mq.delete(idx[0]);
            if (wv) foreach (mq[i]) if (mq[i].tag == int'(wt)) mq[i].rdy = 1'b1;
            if (exp_rdy)
                for (int k = 0; k < 2; k++)
                    if (dv[k]) mq.push_back('{tag: int'(dt[k*8 +: 8]), st: ds[k], rdy: dr[k]});
        end
        if (mrep && !mret && mcnt < MISS_MAX) mcnt++;
        else if (mret && !mrep && mcnt > 0) mcnt--;
    endtask

    task automatic idle();
        step(2'b00, 2'b00, 2'b00, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(iss_valid == 2'b00, "R9", "iss_valid after reset", int'(iss_valid), 0);
        chk(disp_ready == 1'b1, "R9", "disp_ready after reset", int'(disp_ready), 1);

        // R4/R8: store 1 not ready, store 2 ready, then load 3 ready
        step(2'b11, 2'b11, 2'b10, {8'd2, 8'd1}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        step(2'b01, 2'b00, 2'b01, {8'd0, 8'd3}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        chk(iss_valid == 2'b00, "R4", "younger store held", int'(iss_valid), 0);
        idle();
        chk(iss_valid == 2'b01 && iss_tag[7:0] == 8'd3, "R4", "load passes stores",
            int'(iss_tag[7:0]), 3);
        step(2'b00, 2'b00, 2'b00, 16'h0, 1'b1, 8'd1, 1'b0, 1'b0, 1'b0);
        chk(iss_valid == 2'b00, "R8", "wake not same cycle", int'(iss_valid), 0);
        idle();
        chk(iss_valid == 2'b01 && iss_tag[7:0] == 8'd1, "R8", "woken store issues",
            int'(iss_tag[7:0]), 1);
        idle();
        chk(iss_valid == 2'b01 && iss_tag[7:0] == 8'd2, "R4", "second store in order",
            int'(iss_tag[7:0]), 2);

        // R5/R6: saturate the miss count
        for (int i = 0; i < MISS_MAX; i++)
            step(2'b00, 2'b00, 2'b00, 16'h0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b0);
        step(2'b11, 2'b10, 2'b11, {8'd11, 8'd10}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        idle();
        chk(iss_valid == 2'b01 && iss_tag[7:0] == 8'd11 && iss_is_store[0],
            "R6", "only store at limit", int'(iss_tag[7:0]), 11);
        step(2'b00, 2'b00, 2'b00, 16'h0, 1'b0, 8'h0, 1'b0, 1'b1, 1'b0);
        chk(iss_valid == 2'b00, "R6", "load still blocked", int'(iss_valid), 0);
        idle();
        chk(iss_valid == 2'b01 && iss_tag[7:0] == 8'd10, "R5", "load after return",
            int'(iss_tag[7:0]), 10);

        // R7: flush drops entries and same-cycle writes
        step(2'b11, 2'b00, 2'b11, {8'd21, 8'd20}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        step(2'b11, 2'b00, 2'b11, {8'd23, 8'd22}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1);
        chk(iss_valid == 2'b00, "R7", "no issue in flush", int'(iss_valid), 0);
        idle();
        chk(iss_valid == 2'b00, "R7", "empty after flush", int'(iss_valid), 0);

        // R1: fill to capacity with unready loads
        for (int i = 0; i < DEPTH / 2; i++)
            step(2'b11, 2'b00, 2'b00, {8'(40 + 2*i + 1), 8'(40 + 2*i)},
                 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        step(2'b11, 2'b00, 2'b11, {8'd91, 8'd90}, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0);
        chk(disp_ready == 1'b0, "R1", "full queue", int'(disp_ready), 0);
        idle();
        chk(iss_valid == 2'b00, "R1", "dropped writes absent", int'(iss_valid), 0);
        step(2'b00, 2'b00, 2'b00, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1);

        // random traffic against the reference model
        for (int c = 0; c < 4000; c++) begin
            logic [1:0] dv, ds, dr;
            logic [15:0] dt;
            logic wv, mrep, mret, fl;
            logic [7:0] wt;
            dv = 2'($urandom); ds = 2'($urandom);
            dr = {($urandom % 5) < 3, ($urandom % 5) < 3};
            dt = {8'(next_tag + 1), 8'(next_tag)};
            next_tag += 2;
            wv = 1'b0; wt = '0;
            if ($urandom % 3 == 0)
                foreach (mq[i]) if (!wv && !mq[i].rdy) begin wv = 1'b1; wt = 8'(mq[i].tag); end
            mret = (mcnt > 0) && ($urandom % 3 == 0);
            mrep = (mcnt < MISS_MAX) && ($urandom % 4 == 0);
            fl   = ($urandom % 200 == 0);
            step(dv, ds, dr, dt, wv, wt, mrep, mret, fl);
        end
        summary();
    end
endmodule